// File: doc/BRIEF.md
# Programmable clock source selector with return synchronizer

This block takes several independent low-speed clock inputs and routes one of them, optionally divided by a programmable ratio, to a single output clock. A host writes a binary select value and one divide setting per input over a simple synchronous register bus in its own fast clock domain. These settings are quasi-static. A glitch on the output while a setting changes is accepted.

Before the combining OR, each divided input is ANDed with its own bit of a one-hot enable, so only the chosen source toggles at that OR. The output clock drives a small result register that captures an application value on each rising edge. That value returns to the host domain through a two-flop synchronizer.

Top module: `clksel_top`

## Requirements
- R1: The select register (address 0, low 2 bits of write data) loads on a rising host-clock edge only when `bus_wr` is high and `bus_addr` is 0. In any other cycle it holds its value.
- R2: The divide register of input i (address 1+i, low 4 bits of write data) loads on a rising host-clock edge only when `bus_wr` is high and the address matches.
- R3: `bus_rdata` combinationally returns the register at `bus_addr`, zero-extended. Any unmapped address returns 0. During a write cycle it still shows the old value, and the new value appears after the edge.
- R4: With `cpu_rst` high at a host-clock edge, the select register returns to 0, all divide settings return to 0 and `res_sync` returns to 0.
- R5: A divide setting of 0 or 1 passes the selected input clock through unchanged, with the same period and high time.
- R6: A divide setting D of 2 or more gives an output period of D input periods. The high time is floor(D/2) input periods, so the duty is 50% for even D and the high phase is one input period shorter than the low phase for odd D.
- R7: A select value with no matching input (3, with three inputs) disables every input, and `clk_out` then stays low.
- R8: Only the selected input reaches `clk_out`. With the other inputs toggling, the output period follows the selected input alone.
- R9: `res_in` is captured on each rising edge of `clk_out`. Once the captured value is stable, `res_sync` shows it within three host-clock cycles. While `clk_out` is stopped, a change on `res_in` does not reach `res_sync`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Host clock for the register bus and the synchronizer |
| cpu_rst | input | 1 | Active-high reset, synchronous to cpu_clk |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-back data for bus_addr |
| clk_in | input | 3 | Independent input clocks |
| res_in | input | 8 | Application value captured on clk_out |
| clk_out | output | 1 | Selected and divided clock |
| res_sync | output | 8 | Captured value in the host domain |

## Verification
A bus write to the select register and a read-back of that same register can fall in the same host cycle. The bench provokes this by holding the write strobe with address 0 while it reads `bus_rdata` before the edge, and then reads it again after the edge. It judges the pair by expecting the old value first and the new value second.

A reprogramming of the divider can also land in the middle of an output period. The bench therefore discards the first output periods after each change and then checks period and high time against the arithmetic expectations of R5 and R6.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
  localparam int unsigned SEL_ADDR      = 0;
  localparam int unsigned DIV_ADDR_BASE = 1;
endpackage

// File: rtl/clksel_regs.sv
`timescale 1ns/1ps
module clksel_regs
  import clksel_pkg::*;
#(
  parameter int unsigned N_CLK  = 3,
  parameter int unsigned SEL_W  = 2,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8
) (
  input  logic                         cpu_clk,
  input  logic                         cpu_rst,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [SEL_W-1:0]             sel_q,
  output logic [N_CLK-1:0][DIV_W-1:0]  div_q
);
  logic hit_sel;
  assign hit_sel = (bus_addr == ADDR_W'(SEL_ADDR));

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      sel_q <= '0;
      div_q <= '0;
    end else if (bus_wr) begin
      if (hit_sel) sel_q <= bus_wdata[SEL_W-1:0];
      for (int i = 0; i < int'(N_CLK); i++) begin
        if (bus_addr == ADDR_W'(DIV_ADDR_BASE + i)) div_q[i] <= bus_wdata[DIV_W-1:0];
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_sel) bus_rdata = DATA_W'(sel_q);
    for (int i = 0; i < int'(N_CLK); i++) begin
      if (bus_addr == ADDR_W'(DIV_ADDR_BASE + i)) bus_rdata = DATA_W'(div_q[i]);
    end
  end

  // R1: select holds when not addressed by a write
  a_r1_sel_hold: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    !(bus_wr && hit_sel) |=> $stable(sel_q));
  // R1: select loads the written value
  a_r1_sel_load: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (bus_wr && hit_sel) |=> (sel_q == $past(bus_wdata[SEL_W-1:0])));
  // R4: reset clears the control state
  a_r4_reset_clear: assert property (@(posedge cpu_clk)
    cpu_rst |=> (sel_q == '0 && div_q == '0));
endmodule

// File: rtl/clksel_div.sv
`timescale 1ns/1ps
module clksel_div #(
  parameter int unsigned DIV_W = 4
) (
  input  logic             clk_src,
  input  logic             arst,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             clk_div
);
  logic [DIV_W-1:0] cnt, cnt_nxt, half;
  logic             q, bypass;

  assign bypass = (div_cfg < DIV_W'(2));
  assign half   = div_cfg >> 1;

  always_comb begin
    if (bypass)                             cnt_nxt = '0;
    else if (cnt >= div_cfg - DIV_W'(1))    cnt_nxt = '0;
    else                                    cnt_nxt = cnt + DIV_W'(1);
  end

  always_ff @(posedge clk_src or posedge arst) begin
    if (arst) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt_nxt;
      q   <= (cnt_nxt < half);
    end
  end

  assign clk_div = bypass ? clk_src : q;

  // R6: the phase counter wraps after the last count of the ratio
  a_r6_wrap: assert property (@(posedge clk_src) disable iff (arst)
    (!bypass && $stable(div_cfg) && (cnt == div_cfg - DIV_W'(1))) |=> (cnt == '0));
  // R6: in divide mode the output is high only in the first half of the ratio
  a_r6_phase: assert property (@(posedge clk_src) disable iff (arst)
    (!bypass && $stable(div_cfg) && q) |-> (cnt < half));
endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
module clksel_gate #(
  parameter int unsigned N_CLK = 3,
  parameter int unsigned SEL_W = 2
) (
  input  logic             cpu_clk,
  input  logic             cpu_rst,
  input  logic [SEL_W-1:0] sel,
  input  logic [N_CLK-1:0] clk_div,
  output logic             clk_out
);
  logic [N_CLK-1:0] en, gated;

  for (genvar g = 0; g < int'(N_CLK); g++) begin : g_lane
    assign en[g]    = (sel == SEL_W'(g));
    assign gated[g] = clk_div[g] & en[g];
  end

  assign clk_out = |gated;

  // R7: no matching input keeps the output low
  a_r7_idle_low: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    (int'(sel) >= int'(N_CLK)) |-> !clk_out);
  // R8: a high output always comes from the selected source
  a_r8_only_selected: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    ((int'(sel) < int'(N_CLK)) && clk_out) |-> clk_div[sel]);
endmodule

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
  parameter int unsigned RES_W = 8
) (
  input  logic             clk_sel,
  input  logic             cpu_clk,
  input  logic             cpu_rst,
  input  logic [RES_W-1:0] res_in,
  output logic [RES_W-1:0] res_sync
);
  logic [RES_W-1:0] res_q, res_meta;

  always_ff @(posedge clk_sel or posedge cpu_rst) begin
    if (cpu_rst) res_q <= '0;
    else         res_q <= res_in;
  end

  always_ff @(posedge cpu_clk) begin
    if (cpu_rst) begin
      res_meta <= '0;
      res_sync <= '0;
    end else begin
      res_meta <= res_q;
      res_sync <= res_meta;
    end
  end

  // R9: a captured value that stays put reaches the host output
  a_r9_sync_follow: assert property (@(posedge cpu_clk) disable iff (cpu_rst)
    ($stable(res_q) && $stable(res_meta)) |=> (res_sync == $past(res_q)));
endmodule

// File: rtl/clksel_top.sv
`timescale 1ns/1ps
module clksel_top #(
  parameter int unsigned N_CLK  = 3,
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned ADDR_W = 3,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned RES_W  = 8
) (
  input  logic              cpu_clk,
  input  logic              cpu_rst,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_CLK-1:0]  clk_in,
  input  logic [RES_W-1:0]  res_in,
  output logic              clk_out,
  output logic [RES_W-1:0]  res_sync
);
  localparam int unsigned SEL_W = (N_CLK > 1) ? $clog2(N_CLK) : 1;

  logic [SEL_W-1:0]            sel_q;
  logic [N_CLK-1:0][DIV_W-1:0] div_q;
  logic [N_CLK-1:0]            clk_div;

  clksel_regs #(.N_CLK(N_CLK), .SEL_W(SEL_W), .DIV_W(DIV_W),
                .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sel_q(sel_q), .div_q(div_q));

  for (genvar g = 0; g < int'(N_CLK); g++) begin : g_div
    clksel_div #(.DIV_W(DIV_W)) u_div (
      .clk_src(clk_in[g]), .arst(cpu_rst), .div_cfg(div_q[g]), .clk_div(clk_div[g]));
  end

  clksel_gate #(.N_CLK(N_CLK), .SEL_W(SEL_W)) u_gate (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .sel(sel_q), .clk_div(clk_div), .clk_out(clk_out));

  clksel_sync #(.RES_W(RES_W)) u_sync (
    .clk_sel(clk_out), .cpu_clk(cpu_clk), .cpu_rst(cpu_rst),
    .res_in(res_in), .res_sync(res_sync));
endmodule

// File: tb/clksel_top_bench.sv
`timescale 1ns/1ps
module clksel_top_bench;
  logic       cpu_clk = 1'b0;
  logic       cpu_rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] clk_in = '0;
  logic [7:0] res_in = '0;
  logic       clk_out;
  logic [7:0] res_sync;

  int checks = 0;
  int errors = 0;
  real tin [3] = '{37.0, 53.0, 71.0};

  clksel_top u_clksel_top (
    .cpu_clk(cpu_clk), .cpu_rst(cpu_rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .clk_in(clk_in), .res_in(res_in),
    .clk_out(clk_out), .res_sync(res_sync));

  always #2 cpu_clk = ~cpu_clk;
  initial forever #18.5 clk_in[0] = ~clk_in[0];
  initial forever #26.5 clk_in[1] = ~clk_in[1];
  initial forever #35.5 clk_in[2] = ~clk_in[2];

  task automatic chk(input bit ok, input string req, input string detail);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s", req, detail);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge cpu_clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge cpu_clk);
    bus_wr = 1'b0;
  endtask

  task automatic read_chk(input logic [2:0] a, input logic [7:0] exp, input string req);
    @(negedge cpu_clk);
    bus_addr = a;
    #1;
    chk(bus_rdata == exp, req, $sformatf("addr %0d actual %0h expected %0h", a, bus_rdata, exp));
  endtask

  function automatic real rabs(input real x);
    return (x < 0.0) ? -x : x;
  endfunction

  task automatic measure(input int s, input int d, input string req);
    real per_exp, hi_exp, t0, t1, t2;
    per_exp = (d < 2) ? tin[s] : tin[s] * d;
    hi_exp  = (d < 2) ? tin[s] / 2.0 : tin[s] * (d / 2);
    repeat (3) @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out); t1 = $realtime;
    @(posedge clk_out); t2 = $realtime;
    chk(rabs((t2 - t0) - per_exp) < 0.01, req,
        $sformatf("sel %0d div %0d period actual %0.3f expected %0.3f", s, d, t2 - t0, per_exp));
    chk(rabs((t1 - t0) - hi_exp) < 0.01, req,
        $sformatf("sel %0d div %0d high actual %0.3f expected %0.3f", s, d, t1 - t0, hi_exp));
  endtask

  initial begin
    repeat (150000) @(posedge cpu_clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int divs [7] = '{0, 1, 2, 3, 4, 5, 7};
    int rises;
    repeat (4) @(negedge cpu_clk);
    cpu_rst = 1'b0;
    // R4: reset state seen through read-back and result output
    read_chk(3'd0, 8'h00, "R4");
    for (int i = 0; i < 3; i++) read_chk(3'(1 + i), 8'h00, "R4");
    chk(res_sync == 8'h00, "R4", $sformatf("res_sync actual %0h expected 0", res_sync));

    // R2 / R3: divider registers and unmapped address
    bus_write(3'd1, 8'hF3); bus_write(3'd2, 8'h05); bus_write(3'd3, 8'h0E);
    read_chk(3'd1, 8'h03, "R2");
    read_chk(3'd2, 8'h05, "R2");
    read_chk(3'd3, 8'h0E, "R2");
    bus_write(3'd7, 8'hFF);
    read_chk(3'd7, 8'h00, "R3");
    read_chk(3'd0, 8'h00, "R1");

    // R1: no strobe, no load
    @(negedge cpu_clk);
    bus_wr = 1'b0; bus_addr = 3'd0; bus_wdata = 8'h02;
    @(negedge cpu_clk); #1;
    chk(bus_rdata == 8'h00, "R1", $sformatf("no strobe actual %0h expected 0", bus_rdata));

    // R3: write and read-back of the select in the same cycle
    @(negedge cpu_clk);
    bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'hFE;
    #1;
    chk(bus_rdata == 8'h00, "R3", $sformatf("during write actual %0h expected 0", bus_rdata));
    @(negedge cpu_clk);
    bus_wr = 1'b0; #1;
    chk(bus_rdata == 8'h02, "R3", $sformatf("after write actual %0h expected 2", bus_rdata));

    // R5 / R6 / R8: sweep of select and divide settings
    for (int s = 0; s < 3; s++) begin
      bus_write(3'd0, 8'(s));
      for (int k = 0; k < 7; k++) begin
        bus_write(3'(1 + s), 8'(divs[k]));
        measure(s, divs[k], divs[k] < 2 ? "R5 R8" : "R6 R8");
      end
    end

    // R9: result capture and return
    bus_write(3'd0, 8'd1); bus_write(3'd2, 8'd0);
    for (int v = 0; v < 3; v++) begin
      res_in = 8'(8'h5A + 8'(v * 37));
      repeat (2) @(posedge clk_out);
      repeat (3) @(posedge cpu_clk);
      @(negedge cpu_clk);
      chk(res_sync == res_in, "R9", $sformatf("actual %0h expected %0h", res_sync, res_in));
    end

    // R7: out-of-range select holds the output low
    bus_write(3'd0, 8'd3);
    rises = 0;
    fork
      begin : watch
        forever begin @(posedge clk_out); rises++; end
      end
      begin
        repeat (200) @(negedge cpu_clk);
        disable watch;
      end
    join
    chk(rises == 0 && clk_out == 1'b0, "R7",
        $sformatf("rises actual %0d expected 0, level %0b", rises, clk_out));

    // R9: value change with the clock stopped stays out of the host domain
    res_in = 8'h11;
    repeat (50) @(negedge cpu_clk);
    chk(res_sync == 8'(8'h5A + 8'd74), "R9",
        $sformatf("stopped clock actual %0h expected %0h", res_sync, 8'(8'h5A + 8'd74)));

    // R4: reset in mid-operation
    @(negedge cpu_clk); cpu_rst = 1'b1;
    @(negedge cpu_clk); cpu_rst = 1'b0;
    read_chk(3'd0, 8'h00, "R4");
    read_chk(3'd2, 8'h00, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule